// File: doc/BRIEF.md
# Timer Compare Match and Waveform Unit

This block sits beside an 8-bit timer/counter and watches the count on two independent channels, A and B. Each channel holds a compare value. On a timer tick where the count equals that value, the channel raises a sticky event flag one clock later. The flag can drive an interrupt request, and it is cleared either by an interrupt acknowledge or by a software write of one. The same match event drives a per-channel waveform level according to a 2-bit output-action field. The counter's top and bottom indicators handle the PWM cases.

A 3-bit waveform-mode field selects a mode class: plain counting, clear-on-match, single-slope PWM or dual-slope PWM. The counter's own sequencing lies outside this block, so the plain and clear-on-match classes behave the same way here. In the two PWM classes, a compare value written by software waits in a shadow buffer. It moves into the active compare register only at the update point: the top of the count for single-slope and the bottom for dual-slope. In the non-PWM classes writes take effect at once. A force strobe applies the output action without a match, and only outside PWM.

Each channel contains two small state machines. The event-flag machine has the states FL_IDLE and FL_RAISED. It moves from FL_IDLE to FL_RAISED on a tick match. It moves from FL_RAISED back to FL_IDLE on an acknowledge or a software clear when no match arrives in the same cycle, and otherwise it stays put. The waveform-level machine has the states LV_LOW and LV_HIGH. It moves from LV_LOW to LV_HIGH on a set or toggle action, and from LV_HIGH to LV_LOW on a clear or toggle action. Any other action holds the state.

Top module: `tmr_cmp_unit`

## Requirements
- R1: Each channel compares `cnt_i` with its own active compare value. A match counts only on cycles where `tick_i` is high, and one channel's match never touches the other channel.
- R2: A tick match raises the channel's flag at the clock edge that samples it, so the flag is visible in the following cycle. With `tick_i` low, an equal count does not raise the flag.
- R3: `irq_req_o[i]` is high exactly when flag i is high and `irq_en_i[i]` is high.
- R4: A high `irq_ack_i[i]` clears flag i at the next edge. If a tick match occurs in the same cycle, the flag stays set.
- R5: A one in `flag_clr_i[i]` clears flag i at the next edge. A zero bit leaves the flag unchanged.
- R6: In the PWM classes, a write goes only to the shadow buffer. The active value loads from the buffer on a tick with `at_top_i` high (single-slope) or with `at_bottom_i` high (dual-slope), and at no other time.
- R7: In the non-PWM classes, a write with `wr_en_i` high reaches the active value selected by `wr_sel_i` (0 = A, 1 = B) at the next edge.
- R8: The class is decoded from `wgm_i[1:0]`: 00 plain, 10 clear-on-match, 11 single-slope PWM, 01 dual-slope PWM. `wgm_i[2]` does not affect the class.
- R9: Outside PWM, on a tick match the channel's `com_i` field acts on its level as follows: 00 none, 01 toggle, 10 clear, 11 set. Channel A uses bits [1:0] and channel B uses bits [3:2].
- R10: In PWM, field 10 clears the level on a tick match and sets it on a tick at bottom. Field 11 does the reverse. Fields 00 and 01 change nothing. A match takes precedence over bottom.
- R11: Outside PWM, `force_i[i]` applies channel i's output action without a tick or match and without raising the flag. In PWM it is ignored.
- R12: After reset, the flags, the active values, the buffers, the interrupt requests and the waveform levels are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable |
| cnt_i | input | CNT_W | Live counter value |
| at_top_i | input | 1 | Counter is at the top of its sequence |
| at_bottom_i | input | 1 | Counter is at the bottom of its sequence |
| wgm_i | input | 3 | Waveform mode field |
| com_i | input | 2*NUM_CH | Per-channel output action field |
| wr_en_i | input | 1 | Compare value write strobe |
| wr_sel_i | input | clog2(NUM_CH) | Channel selected for the write |
| wr_data_i | input | CNT_W | Compare value to write |
| flag_clr_i | input | NUM_CH | Write-one-to-clear flag bits |
| irq_en_i | input | NUM_CH | Interrupt enables |
| irq_ack_i | input | NUM_CH | Interrupt acknowledges |
| force_i | input | NUM_CH | Force-compare strobes |
| cmp_val_o | output | CNT_W*NUM_CH | Active compare values, channel A in the low byte |
| cmp_flag_o | output | NUM_CH | Compare event flags |
| irq_req_o | output | NUM_CH | Interrupt requests |
| wave_o | output | NUM_CH | Waveform levels |

## Verification
The bench writes a compare value in PWM and then gives ticks at the wrong extreme. A design that loaded from the buffer at once, or at the wrong extreme for the slope, would show a changed active value too early. It raises a match and an acknowledge in the same cycle, where a design that let the clear win would lose the event. It presents an equal count with the tick low, where a design that ignored the enable would set the flag. It also strobes force, expecting the level to move with no flag outside PWM and nothing to change inside PWM, and it checks that `wgm_i[2]` does not alter the class.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    typedef enum logic [1:0] {
        MC_NORMAL       = 2'd0,
        MC_CLR_ON_MATCH = 2'd1,
        MC_PWM_SINGLE   = 2'd2,
        MC_PWM_DUAL     = 2'd3
    } mode_cls_e;

    typedef enum logic [1:0] {
        WA_NONE   = 2'd0,
        WA_TOGGLE = 2'd1,
        WA_CLEAR  = 2'd2,
        WA_SET    = 2'd3
    } wave_act_e;

    typedef enum logic {
        LV_LOW  = 1'b0,
        LV_HIGH = 1'b1
    } wave_lvl_e;

    typedef enum logic {
        FL_IDLE   = 1'b0,
        FL_RAISED = 1'b1
    } flag_st_e;

endpackage

// File: rtl/tcu_mode_dec.sv
module tcu_mode_dec
    import tcu_pkg::*;
(
    input  logic [2:0] wgm_i,
    output logic       pwm_o,
    output logic       load_top_o
);

    mode_cls_e cls;

    // R8: only the two low bits pick the class
    always_comb begin
        unique case (wgm_i)
            3'b000, 3'b100: cls = MC_NORMAL;
            3'b010, 3'b110: cls = MC_CLR_ON_MATCH;
            3'b011, 3'b111: cls = MC_PWM_SINGLE;
            3'b001, 3'b101: cls = MC_PWM_DUAL;
        endcase
    end

    always_comb begin
        pwm_o      = (cls == MC_PWM_SINGLE) || (cls == MC_PWM_DUAL);
        load_top_o = (cls == MC_PWM_SINGLE);
    end

endmodule

// File: rtl/tcu_ocr_buf.sv
module tcu_ocr_buf #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         pwm_i,
    input  logic         load_top_i,
    input  logic         top_i,
    input  logic         bottom_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] active_o
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;
    logic         load_pt;

    assign load_pt  = tick_i && (load_top_i ? top_i : bottom_i);
    assign active_o = active_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en_i) begin
                shadow_q <= wr_data_i;
            end
            if (!pwm_i) begin
                if (wr_en_i) begin
                    active_q <= wr_data_i;
                end
            end else if (load_pt) begin
                active_q <= shadow_q;
            end
        end
    end

    AST_PWM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwm_i && !load_pt) |=> $stable(active_o)); // R6

    AST_DIRECT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwm_i && wr_en_i) |=> (active_o == $past(wr_data_i))); // R7

endmodule

// File: rtl/tcu_flag.sv
module tcu_flag
    import tcu_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic ack_i,
    input  logic sw_clr_i,
    output logic flag_o
);

    flag_st_e st_q;
    flag_st_e st_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= FL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_IDLE: begin
                if (hit_i) st_d = FL_RAISED;
            end
            FL_RAISED: begin
                if (!hit_i && (ack_i || sw_clr_i)) st_d = FL_IDLE;
            end
        endcase
    end

    always_comb begin
        flag_o = (st_q == FL_RAISED);
    end

    AST_FLAG_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) |-> $past(hit_i)); // R2

    AST_HIT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i |=> flag_o); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && ack_i && !hit_i) |=> !flag_o); // R4

    AST_SWCLR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && sw_clr_i && !hit_i) |=> !flag_o); // R5

endmodule

// File: rtl/tcu_wave.sv
module tcu_wave
    import tcu_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwm_i,
    input  logic [1:0] com_i,
    input  logic       hit_i,
    input  logic       bottom_tick_i,
    input  logic       force_i,
    output logic       level_o
);

    wave_act_e act;
    wave_lvl_e lvl_q;
    wave_lvl_e lvl_d;

    // Action selection: R9 outside PWM, R10 inside PWM, R11 for force
    always_comb begin
        act = WA_NONE;
        if (!pwm_i) begin
            if (hit_i || force_i) begin
                unique case (com_i)
                    2'b00: act = WA_NONE;
                    2'b01: act = WA_TOGGLE;
                    2'b10: act = WA_CLEAR;
                    2'b11: act = WA_SET;
                endcase
            end
        end else if (hit_i) begin
            if (com_i == 2'b10) act = WA_CLEAR;
            else if (com_i == 2'b11) act = WA_SET;
        end else if (bottom_tick_i) begin
            if (com_i == 2'b10) act = WA_SET;
            else if (com_i == 2'b11) act = WA_CLEAR;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_q <= LV_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LV_LOW: begin
                if (act == WA_SET || act == WA_TOGGLE) lvl_d = LV_HIGH;
            end
            LV_HIGH: begin
                if (act == WA_CLEAR || act == WA_TOGGLE) lvl_d = LV_LOW;
            end
        endcase
    end

    always_comb begin
        level_o = (lvl_q == LV_HIGH);
    end

    AST_PWM_FORCE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwm_i && force_i && !hit_i && !bottom_tick_i) |=> $stable(level_o)); // R11

    AST_DISCONNECTED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (com_i == 2'b00) |=> $stable(level_o)); // R9

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2
) (
    input  logic                                              clk_i,
    input  logic                                              rst_ni,
    input  logic                                              tick_i,
    input  logic [CNT_W-1:0]                                  cnt_i,
    input  logic                                              at_top_i,
    input  logic                                              at_bottom_i,
    input  logic [2:0]                                        wgm_i,
    input  logic [2*NUM_CH-1:0]                               com_i,
    input  logic                                              wr_en_i,
    input  logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0]    wr_sel_i,
    input  logic [CNT_W-1:0]                                  wr_data_i,
    input  logic [NUM_CH-1:0]                                 flag_clr_i,
    input  logic [NUM_CH-1:0]                                 irq_en_i,
    input  logic [NUM_CH-1:0]                                 irq_ack_i,
    input  logic [NUM_CH-1:0]                                 force_i,
    output logic [CNT_W*NUM_CH-1:0]                           cmp_val_o,
    output logic [NUM_CH-1:0]                                 cmp_flag_o,
    output logic [NUM_CH-1:0]                                 irq_req_o,
    output logic [NUM_CH-1:0]                                 wave_o
);

    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              pwm;
    logic              load_top;
    logic              bottom_tick;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] ch_wr;

    assign bottom_tick = tick_i && at_bottom_i;
    assign irq_req_o   = cmp_flag_o & irq_en_i;

    tcu_mode_dec u_mode (
        .wgm_i      (wgm_i),
        .pwm_o      (pwm),
        .load_top_o (load_top)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CNT_W-1:0] active;

        assign ch_wr[ch] = wr_en_i && (wr_sel_i == SEL_W'(ch));
        assign hit[ch]   = tick_i && (cnt_i == active);
        assign cmp_val_o[ch*CNT_W +: CNT_W] = active;

        tcu_ocr_buf #(.W(CNT_W)) u_buf (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .tick_i     (tick_i),
            .pwm_i      (pwm),
            .load_top_i (load_top),
            .top_i      (at_top_i),
            .bottom_i   (at_bottom_i),
            .wr_en_i    (ch_wr[ch]),
            .wr_data_i  (wr_data_i),
            .active_o   (active)
        );

        tcu_flag u_flag (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .hit_i    (hit[ch]),
            .ack_i    (irq_ack_i[ch]),
            .sw_clr_i (flag_clr_i[ch]),
            .flag_o   (cmp_flag_o[ch])
        );

        tcu_wave u_wave (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .pwm_i         (pwm),
            .com_i         (com_i[2*ch +: 2]),
            .hit_i         (hit[ch]),
            .bottom_tick_i (bottom_tick),
            .force_i       (force_i[ch]),
            .level_o       (wave_o[ch])
        );

        AST_FORCE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (force_i[ch] && !hit[ch] && !cmp_flag_o[ch]) |=> !cmp_flag_o[ch]); // R11

        AST_NO_TICK_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!tick_i && !cmp_flag_o[ch]) |=> !cmp_flag_o[ch]); // R2
    end

endmodule

// File: tb/tmr_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_cmp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  cnt = '0;
    logic        at_top = 1'b0;
    logic        at_bot = 1'b0;
    logic [2:0]  wgm = '0;
    logic [3:0]  com = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  fclr = '0;
    logic [1:0]  ien = '0;
    logic [1:0]  iack = '0;
    logic [1:0]  frc = '0;
    logic [15:0] cval;
    logic [1:0]  flag;
    logic [1:0]  irq;
    logic [1:0]  wave;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmr_cmp_unit dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .cnt_i      (cnt),
        .at_top_i   (at_top),
        .at_bottom_i(at_bot),
        .wgm_i      (wgm),
        .com_i      (com),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .flag_clr_i (fclr),
        .irq_en_i   (ien),
        .irq_ack_i  (iack),
        .force_i    (frc),
        .cmp_val_o  (cval),
        .cmp_flag_o (flag),
        .irq_req_o  (irq),
        .wave_o     (wave)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick(input logic [7:0] c, input logic top, input logic bot);
        cnt = c; at_top = top; at_bot = bot; tick = 1'b1;
        cycle();
        tick = 1'b0; at_top = 1'b0; at_bot = 1'b0;
    endtask

    task automatic clear_flags();
        fclr = 2'b11;
        cycle();
        fclr = 2'b00;
    endtask

    task automatic t_reset();
        check("R12", "flags", 16'(flag), 16'h0);
        check("R12", "active values", cval, 16'h0);
        check("R12", "irq", 16'(irq), 16'h0);
        check("R12", "wave", 16'(wave), 16'h0);
    endtask

    task automatic t_direct();
        wgm = 3'b000;
        wr_reg(1'b0, 8'h40);
        check("R7", "A direct write", cval, 16'h0040);
        wr_reg(1'b1, 8'h10);
        check("R7", "B direct write", cval, 16'h1040);
        wgm = 3'b110;
        wr_reg(1'b0, 8'h41);
        check("R8", "wgm 110 writes through", cval, 16'h1041);
        wr_reg(1'b0, 8'h40);
        wgm = 3'b000;
    endtask

    task automatic t_match();
        cnt = 8'h40; tick = 1'b0;
        cycle();
        check("R2", "no flag without tick", 16'(flag), 16'h0);
        pulse_tick(8'h40, 1'b0, 1'b0);
        check("R1", "only A flag after A match", 16'(flag), 16'h1);
        cycle();
        check("R2", "flag sticky", 16'(flag), 16'h1);
        ien = 2'b00; #1;
        check("R3", "irq masked", 16'(irq), 16'h0);
        ien = 2'b01; #1;
        check("R3", "irq enabled", 16'(irq), 16'h1);
        ien = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_swclr();
        fclr = 2'b10;
        cycle();
        fclr = 2'b00;
        check("R5", "zero bit leaves A flag", 16'(flag), 16'h1);
        fclr = 2'b01;
        cycle();
        fclr = 2'b00;
        check("R5", "one bit clears A flag", 16'(flag), 16'h0);
    endtask

    task automatic t_ack();
        pulse_tick(8'h40, 1'b0, 1'b0);
        iack = 2'b01;
        cycle();
        iack = 2'b00;
        check("R4", "ack clears", 16'(flag), 16'h0);
        cnt = 8'h40; tick = 1'b1;
        cycle();
        check("R4", "set wins over ack (arm)", 16'(flag), 16'h1);
        iack = 2'b01;
        cycle();
        iack = 2'b00; tick = 1'b0;
        check("R4", "match and ack same cycle", 16'(flag), 16'h1);
        clear_flags();
        pulse_tick(8'h10, 1'b0, 1'b0);
        check("R1", "B flag from B match", 16'(flag), 16'h2);
        clear_flags();
    endtask

    task automatic t_wave_nonpwm();
        wgm = 3'b000;
        com = 4'b0001;
        pulse_tick(8'h40, 1'b0, 1'b0);
        check("R9", "toggle to high", 16'(wave), 16'h1);
        pulse_tick(8'h40, 1'b0, 1'b0);
        check("R9", "toggle to low", 16'(wave), 16'h0);
        com = 4'b0011;
        pulse_tick(8'h40, 1'b0, 1'b0);
        check("R9", "set on match", 16'(wave), 16'h1);
        com = 4'b0000;
        pulse_tick(8'h40, 1'b0, 1'b0);
        check("R9", "disconnected holds", 16'(wave), 16'h1);
        com = 4'b0010;
        pulse_tick(8'h40, 1'b0, 1'b0);
        check("R9", "clear on match", 16'(wave), 16'h0);
        com = 4'b0100;
        pulse_tick(8'h10, 1'b0, 1'b0);
        check("R9", "B toggle only", 16'(wave), 16'h2);
        com = 4'b1000;
        pulse_tick(8'h10, 1'b0, 1'b0);
        check("R9", "B clear", 16'(wave), 16'h0);
        com = 4'b0000;
        clear_flags();
    endtask

    task automatic t_force();
        wgm = 3'b000; cnt = 8'h00; com = 4'b0011;
        frc = 2'b01;
        cycle();
        frc = 2'b00;
        check("R11", "force sets level", 16'(wave), 16'h1);
        check("R11", "force raises no flag", 16'(flag), 16'h0);
        com = 4'b0010;
        frc = 2'b01;
        cycle();
        frc = 2'b00;
        check("R11", "force clears level", 16'(wave), 16'h0);
        com = 4'b0000;
    endtask

    task automatic t_pwm_single();
        wgm = 3'b011; com = 4'b0000;
        wr_reg(1'b0, 8'h80);
        check("R6", "write buffered", cval, 16'h1040);
        pulse_tick(8'h33, 1'b0, 1'b1);
        check("R6", "no load at bottom in single slope", cval, 16'h1040);
        pulse_tick(8'h33, 1'b1, 1'b0);
        check("R6", "load at top", cval, 16'h1080);
        com = 4'b0011;
        cnt = 8'h00;
        frc = 2'b01;
        cycle();
        frc = 2'b00;
        check("R11", "force ignored in PWM", 16'(wave), 16'h0);
    endtask

    task automatic t_pwm_wave();
        wgm = 3'b011;
        com = 4'b0010;
        pulse_tick(8'h00, 1'b0, 1'b1);
        check("R10", "mode 10 sets at bottom", 16'(wave), 16'h1);
        pulse_tick(8'h80, 1'b0, 1'b0);
        check("R10", "mode 10 clears on match", 16'(wave), 16'h0);
        com = 4'b0011;
        pulse_tick(8'h80, 1'b0, 1'b0);
        check("R10", "mode 11 sets on match", 16'(wave), 16'h1);
        pulse_tick(8'h00, 1'b0, 1'b1);
        check("R10", "mode 11 clears at bottom", 16'(wave), 16'h0);
        com = 4'b0001;
        pulse_tick(8'h80, 1'b0, 1'b0);
        check("R10", "mode 01 no action in PWM", 16'(wave), 16'h0);
        com = 4'b0000;
        clear_flags();
    endtask

    task automatic t_pwm_dual();
        wgm = 3'b101;
        wr_reg(1'b0, 8'h20);
        check("R6", "dual write buffered", cval, 16'h1080);
        pulse_tick(8'h55, 1'b1, 1'b0);
        check("R8", "wgm 101 is dual slope, no load at top", cval, 16'h1080);
        pulse_tick(8'h55, 1'b0, 1'b1);
        check("R6", "dual load at bottom", cval, 16'h1020);
        wgm = 3'b000;
    endtask

    initial begin : watchdog
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_match();
        t_swclr();
        t_ack();
        t_wave_nonpwm();
        t_force();
        t_pwm_single();
        t_pwm_wave();
        t_pwm_dual();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule